// File: doc/BRIEF.md
# Sigma-Delta Ramp Playback Sequencer

This block stores a precomputed one-bit sigma-delta stream that encodes one full period of a sawtooth. On command it plays that stream out one bit per clock toward an external one-bit DAC and low-pass filter, which turn it back into a slow linear ramp for converter self-test. The stream is written in through a bit-wide write port before the test starts. Playback runs for as long as the enable is held, and the address wraps back to zero after the last stored bit, so the ramp repeats period after period.

Alongside the bit stream, the block raises an acquire strobe for downstream capture logic. The strobe covers only a programmable span of addresses, the straight part of the rising ramp; the start is inclusive and the end is exclusive. A period counter steps once per completed pass, so a controller can tell when a whole sawtooth has been emitted. The block holds a power-of-two number of bits set by a width parameter. Full-size use takes 14 address bits, and the default is smaller so that elaboration stays light.

Top module: `sdr_ramp_player`

## Requirements
- R1: While rst_n is low, and on the first sampling after it rises, bit_out, acquire and run_count are all 0.
- R2: After the first rising edge with play_en sampled high, bit_out presents the stored bit at address 0. Each following edge with play_en high presents the next address, so the k-th such edge (k from 1) presents address k-1.
- R3: After the bit at address 2^ADDR_W-1 has been presented, the next edge with play_en high presents address 0 again, with no gap.
- R4: run_count rises by exactly 1 on the same edge that presents the bit at the last address, and it is otherwise unchanged. Only rst_n clears it.
- R5: acquire is 1 on an edge exactly when the address being presented, a, satisfies lo <= a < hi, where lo and hi are the captured window bounds. When lo >= hi, acquire never rises. Because hi is ADDR_W bits wide, the last address can never be inside the window.
- R6: On the first edge with play_en sampled low, bit_out and acquire go to 0 and run_count holds its value. The next time playback starts, it begins at address 0.
- R7: A write (wr_en=1) on an edge with play_en low stores wr_data at wr_addr. A write on an edge with play_en high leaves the memory unchanged.
- R8: win_lo and win_hi are captured on every edge with play_en low. While play_en is high the captured bounds stay frozen, so input changes take effect only after playback stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | ADDR_W | Pattern write address |
| wr_data | input | 1 | Pattern write bit |
| win_lo | input | ADDR_W | First address inside the acquire window |
| win_hi | input | ADDR_W | First address past the acquire window |
| bit_out | output | 1 | Serial stream bit toward the one-bit DAC |
| acquire | output | 1 | High while the presented address is inside the window |
| run_count | output | RUN_W | Completed-period counter |

## Verification
The stream is checked cycle by cycle against a hashed irregular pattern and against a strictly alternating pattern. A wrong address step, an off-by-one alignment or a missed wrap shows up as a mismatch within a few bits. Windows are tried in several forms: one in the middle of the period, one starting at address 0, one running up to the last address, one that is empty, and one with its bounds reversed. Together these separate the inclusive lower bound from the exclusive upper bound. Writes and window changes made during playback are followed by observing the addresses they would have affected, both later in the same pass and after a restart. This confirms that they were dropped or held back, and not merely delayed.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int SDR_ADDR_W_DEF = 10;
    localparam int SDR_RUN_W_DEF  = 8;

    // half-open span test shared by window logic
    function automatic logic span_hit(input logic [31:0] a,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/sdr_bitmem.sv
module sdr_bitmem #(
    parameter int ADDR_W = sdr_pkg::SDR_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && !wr_lock) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_bit = mem_q[rd_addr];

    p_locked_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock) |=> mem_q[$past(wr_addr)] == $past(mem_q[wr_addr]));

    p_open_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_lock) |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/sdr_addr_gen.sv
module sdr_addr_gen #(
    parameter int ADDR_W = sdr_pkg::SDR_ADDR_W_DEF,
    parameter int RUN_W  = sdr_pkg::SDR_RUN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic [ADDR_W-1:0] addr,
    output logic [RUN_W-1:0]  runs
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RUN_W-1:0]  runs;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (!run_en) begin
            ag_d.addr = '0;
        end else if (ag_q.addr == LAST) begin
            ag_d.addr = '0;
            ag_d.runs = ag_q.runs + 1'b1;
        end else begin
            ag_d.addr = ag_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr = ag_q.addr;
    assign runs = ag_q.runs;

    p_idle_addr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ag_q.addr == '0);

    p_addr_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && ag_q.addr != LAST) |=> ag_q.addr == ADDR_W'($past(ag_q.addr) + 1'b1));

    p_wrap_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && ag_q.addr == LAST) |=>
            (ag_q.addr == '0) && (ag_q.runs == RUN_W'($past(ag_q.runs) + 1'b1)));

    p_runs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && ag_q.addr == LAST) |=> $stable(ag_q.runs));

endmodule

// File: rtl/sdr_window.sv
module sdr_window #(
    parameter int ADDR_W = sdr_pkg::SDR_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] lo_in,
    input  logic [ADDR_W-1:0] hi_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (!freeze) begin
            win_d.lo = lo_in;
            win_d.hi = hi_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign hit = sdr_pkg::span_hit(32'(addr), 32'(win_q.lo), 32'(win_q.hi));

    p_bounds_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(win_q.lo) && $stable(win_q.hi));

    p_bounds_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> (win_q.lo == $past(lo_in)) && (win_q.hi == $past(hi_in)));

endmodule

// File: rtl/sdr_ramp_player.sv
module sdr_ramp_player #(
    parameter int ADDR_W = sdr_pkg::SDR_ADDR_W_DEF,
    parameter int RUN_W  = sdr_pkg::SDR_RUN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic              bit_out,
    output logic              acquire,
    output logic [RUN_W-1:0]  run_count
);
    typedef struct packed {
        logic bit_v;
        logic acq;
    } out_t;

    logic [ADDR_W-1:0] rd_addr;
    logic              rd_bit;
    logic              in_win;
    out_t              out_d, out_q;

    sdr_addr_gen #(.ADDR_W(ADDR_W), .RUN_W(RUN_W)) addr_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (play_en),
        .addr   (rd_addr),
        .runs   (run_count)
    );

    sdr_bitmem #(.ADDR_W(ADDR_W)) bitmem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lock (play_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    sdr_window #(.ADDR_W(ADDR_W)) window_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (play_en),
        .lo_in  (win_lo),
        .hi_in  (win_hi),
        .addr   (rd_addr),
        .hit    (in_win)
    );

    always_comb begin
        out_d = '0;
        if (play_en) begin
            out_d.bit_v = rd_bit;
            out_d.acq   = in_win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bit_out = out_q.bit_v;
    assign acquire = out_q.acq;

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !bit_out && !acquire);

    p_idle_runs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> $stable(run_count));

endmodule

// File: tb/sdr_ramp_player_tb.sv
module sdr_ramp_player_tb_top;
    localparam int AW = 10;
    localparam int RW = 8;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          play_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_data = 1'b0;
    logic [AW-1:0] win_lo = '0;
    logic [AW-1:0] win_hi = '0;
    logic          bit_out;
    logic          acquire;
    logic [RW-1:0] run_count;

    always #10 clk = ~clk;

    sdr_ramp_player #(.ADDR_W(AW), .RUN_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .play_en(play_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .win_lo(win_lo), .win_hi(win_hi),
        .bit_out(bit_out), .acquire(acquire), .run_count(run_count)
    );

    int n_chk = 0;
    int n_err = 0;
    bit ref_mem [D];
    int exp_run = 0;
    int act_lo = 0;
    int act_hi = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pat(input int kind, input int a);
        if (kind == 0) return ((a * 13 + (a >> 3) + (a >> 7)) % 7) < 3;
        return a[0];
    endfunction

    // one edge with playback off: window bounds are captured (R8)
    task automatic idle_edge();
        @(negedge clk);
        act_lo = int'(win_lo);
        act_hi = int'(win_hi);
    endtask

    task automatic set_win(input int lo, input int hi);
        win_lo = AW'(lo);
        win_hi = AW'(hi);
        idle_edge();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "bit_out in reset", int'(bit_out), 0);
        check("R1", "acquire in reset", int'(acquire), 0);
        check("R1", "run_count in reset", int'(run_count), 0);
        rst_n = 1'b1;
        idle_edge();
        check("R1", "bit_out after reset", int'(bit_out), 0);
        check("R1", "acquire after reset", int'(acquire), 0);
        check("R1", "run_count after reset", int'(run_count), 0);
        exp_run = 0;
    endtask

    // writes every address with playback off (R7 stores)
    task automatic t_load(input int kind);
        for (int a = 0; a < D; a++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(a);
            wr_data = pat(kind, a);
            ref_mem[a] = pat(kind, a);
            idle_edge();
        end
        wr_en = 1'b0;
    endtask

    task automatic t_play(input int n,
                          input int poke_k, input int poke_addr, input bit poke_val,
                          input int chg_k, input int chg_lo, input int chg_hi);
        play_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            int    a;
            string rb;
            string ra;
            @(negedge clk);
            a = k % D;
            if (a == D - 1) exp_run = (exp_run + 1) % (1 << RW);
            rb = (k >= D) ? "R3" : "R2";
            if (poke_k >= 0 && k > poke_k && a == poke_addr) rb = "R7";
            ra = (chg_k >= 0 && k > chg_k) ? "R8" : "R5";
            check(rb, $sformatf("bit_out at addr %0d", a), int'(bit_out), int'(ref_mem[a]));
            check(ra, $sformatf("acquire at addr %0d", a), int'(acquire),
                  int'(a >= act_lo && a < act_hi));
            check("R4", $sformatf("run_count at addr %0d", a), int'(run_count), exp_run);
            wr_en = (k == poke_k);
            if (k == poke_k) begin
                wr_addr = AW'(poke_addr);
                wr_data = poke_val;
            end
            if (k == chg_k) begin
                win_lo = AW'(chg_lo);
                win_hi = AW'(chg_hi);
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic t_stop();
        play_en = 1'b0;
        idle_edge();
        check("R6", "bit_out after stop", int'(bit_out), 0);
        check("R6", "acquire after stop", int'(acquire), 0);
        check("R6", "run_count after stop", int'(run_count), exp_run);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1
        t_reset();

        // R2 R3 R4 R5: irregular stream over one wrap, mid window
        t_load(0);
        set_win(30, 300);
        t_play(D + 80, -1, 0, 1'b0, -1, 0, 0);
        t_stop();

        // R6 R7 R8: restart at 0, write and window change during play are held off
        t_play(60, 10, 50, ~ref_mem[50], 20, 0, 5);
        t_stop();
        // R8: new window applies after stop; R5 lower bound at address 0
        t_play(20, -1, 0, 1'b0, -1, 0, 0);
        t_stop();

        // R5: empty and reversed windows never acquire
        set_win(7, 7);
        t_play(40, -1, 0, 1'b0, -1, 0, 0);
        t_stop();
        set_win(900, 100);
        t_play(40, -1, 0, 1'b0, -1, 0, 0);
        t_stop();

        // R5: window up to the top, last address excluded
        set_win(1000, D - 1);
        t_play(D + 6, -1, 0, 1'b0, -1, 0, 0);
        t_stop();

        // R7: rewrite with playback off lands
        t_load(1);
        t_play(30, -1, 0, 1'b0, -1, 0, 0);
        t_stop();

        summary();
        $finish;
    end
endmodule